// File: doc/BRIEF.md
# Microwire EEPROM Transaction Monitor

This block listens on a four-signal serial memory bus: chip select, serial clock, the line from master to memory and the line from memory to master. It never drives the bus. It rebuilds each framed transaction and reports which serial-EEPROM instruction it was, the address it carried, and the data words that crossed the bus. A debug or trace path inside a larger chip would use it to log memory traffic without disturbing the memory.

All four bus lines are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. A frame opens on a rising chip select. The first master-to-memory bit sampled high is taken as the start bit. After it come a two-bit opcode and an address field. A read then streams words back from the memory line until the frame closes. A write or a write-all carries exactly one data word on the master line. When chip select falls, a one-cycle completion strobe carries the decoded instruction, the address and two diagnostic flags. The frame state then clears for the next transaction.

Top module: `mwmon_top`

## Requirements
- R1: After the start bit, the first two master-line bits (MSB first) select the instruction, which is reported on `cmd_o` during `done_o`. Opcode 10 gives READ (code 0), 01 gives WRITE (code 1) and 11 gives ERASE (code 2).
- R2: With opcode 00, the two most significant address bits select an extended command: 11 gives enable-writes (code 3), 00 gives disable-writes (code 4), 10 gives erase-all (code 5) and 01 gives write-all (code 6).
- R3: The ADDR_W bits after the opcode are assembled MSB first and reported on `addr_o` with `done_o`.
- R4: In a READ, every complete group of WORD_W memory-line bits after the address is presented on `word_o` with a one-cycle `word_valid_o` and `word_dir_o`=0. This continues for as long as the frame lasts.
- R5: In a WRITE or write-all, the first WORD_W master-line bits after the address form exactly one word, presented with `word_dir_o`=1. Later bits in the same frame produce no word. ERASE and the other extended commands produce no word.
- R6: A frame that ends with fewer than 2+ADDR_W bits after the start bit raises `short_pkt_o` with `done_o`, and `cmd_o` is NONE (code 7).
- R7: `short_word_o` rises with `done_o` when a READ ends partway through a word, or when a WRITE or write-all ends before its data word is complete. It is never raised together with `short_pkt_o`.
- R8: Master-line bits sampled low before the start bit are ignored, and the start bit is not part of the opcode. A frame with no start bit is reported as a short packet.
- R9: Each falling chip select that closes a frame gives exactly one single-cycle `done_o`, never in the same cycle as `word_valid_o`. The next frame decodes independently.
- R10: After reset, and in every cycle without `done_o`, `done_o`, `short_pkt_o`, `short_word_o` and `word_valid_o` are low, except for `word_valid_o` pulses defined in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Bus chip select (asynchronous) |
| sk_i | input | 1 | Bus serial clock (asynchronous) |
| si_i | input | 1 | Master-to-memory data line |
| so_i | input | 1 | Memory-to-master data line |
| done_o | output | 1 | One-cycle end-of-frame strobe |
| cmd_o | output | 3 | Decoded instruction code, valid with done_o |
| addr_o | output | ADDR_W | Decoded address, valid with done_o |
| short_pkt_o | output | 1 | Frame too short for opcode and address |
| short_word_o | output | 1 | Data word cut off by end of frame |
| word_valid_o | output | 1 | One-cycle strobe for a decoded word |
| word_dir_o | output | 1 | 1 = word from master line, 0 = from memory line |
| word_o | output | WORD_W | Decoded word, MSB first on the bus |

## Verification
The bound checker watches on every cycle that the completion strobe is a single pulse and never meets a word strobe. It also checks that diagnostic flags appear only with completion and never both at once, that word strobes are spaced apart, and that a frame yields at most one master-line word, reported only for a write or a write-all. The exact instruction codes, the MSB-first assembly of addresses and words, the tolerance of leading zeros before the start bit, and the read stream that continues across several words can be shown only by the bench's frames, which compare each report against the bits that were sent.

// File: rtl/mwmon_pkg.sv
// Package: shared types and decode helper for the serial-EEPROM bus monitor.
// Assumes: two-bit opcode, extended commands chosen by two address MSBs.
package mwmon_pkg;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_ERASE = 3'd2,
        CMD_WEN   = 3'd3,
        CMD_WDS   = 3'd4,
        CMD_ERAL  = 3'd5,
        CMD_WRAL  = 3'd6,
        CMD_NONE  = 3'd7
    } mw_cmd_e;

    typedef enum logic [1:0] {
        DP_IDLE   = 2'd0,
        DP_STREAM = 2'd1,
        DP_ONCE   = 2'd2
    } mw_dphase_e;

    // Map opcode and extended selector to an instruction code.
    function automatic mw_cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] ext);
        mw_cmd_e c;
        case (op)
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            2'b11:   c = CMD_ERASE;
            default: begin
                case (ext)
                    2'b11:   c = CMD_WEN;
                    2'b00:   c = CMD_WDS;
                    2'b10:   c = CMD_ERAL;
                    default: c = CMD_WRAL;
                endcase
            end
        endcase
        return c;
    endfunction

    // Data-phase behaviour implied by an instruction.
    function automatic mw_dphase_e phase_of(input mw_cmd_e c);
        mw_dphase_e p;
        case (c)
            CMD_READ:           p = DP_STREAM;
            CMD_WRITE, CMD_WRAL: p = DP_ONCE;
            default:            p = DP_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mwmon_sync.sv
// Module: multi-bit double-flop synchronizer with edge detection.
// Assumes: each input bit is an independent, slowly changing level;
// rise/fall are single-cycle pulses in the clk domain.
module mwmon_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        // Shift the raw input through the synchronizer stages.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i[i]};
        end
        assign lvl_o[i] = chain_q[STAGES-1];
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_o;
    end

    assign rise_o = lvl_o & ~prev_q;
    assign fall_o = ~lvl_o & prev_q;

endmodule

// File: rtl/mwmon_hdr.sv
// Module: frame tracker; finds the start bit, collects opcode and address,
// and issues the end-of-frame report with diagnostic flags.
// Assumes: synchronized levels and single-cycle edge pulses at its inputs.
module mwmon_hdr
    import mwmon_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise_i,
    input  logic              cs_fall_i,
    input  logic              sk_rise_i,
    input  logic              si_i,
    input  logic              word_partial_i,
    input  logic              word_taken_i,
    output logic              hdr_full_o,
    output mw_cmd_e           cmd_cur_o,
    output logic              done_o,
    output mw_cmd_e           cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              short_pkt_o,
    output logic              short_word_o
);

    localparam int HDR_W = 2 + ADDR_W;
    localparam int CNT_W = $clog2(HDR_W + 1);

    logic             active_q;
    logic             started_q;
    logic [CNT_W-1:0] hcnt_q;
    logic [HDR_W-1:0] hsr_q;
    logic             cut_word;

    assign hdr_full_o = (hcnt_q == CNT_W'(HDR_W));
    assign cmd_cur_o  = decode_cmd(hsr_q[HDR_W-1 -: 2], hsr_q[ADDR_W-1 -: 2]);

    // Decide whether the data word of the current instruction was cut off.
    always_comb begin
        case (phase_of(cmd_cur_o))
            DP_STREAM: cut_word = word_partial_i;
            DP_ONCE:   cut_word = !word_taken_i;
            default:   cut_word = 1'b0;
        endcase
    end

    // Track the frame, shift header bits, and report at chip-select fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q     <= 1'b0;
            started_q    <= 1'b0;
            hcnt_q       <= '0;
            hsr_q        <= '0;
            done_o       <= 1'b0;
            cmd_o        <= CMD_NONE;
            addr_o       <= '0;
            short_pkt_o  <= 1'b0;
            short_word_o <= 1'b0;
        end else begin
            done_o       <= 1'b0;
            short_pkt_o  <= 1'b0;
            short_word_o <= 1'b0;
            if (cs_rise_i) begin
                active_q  <= 1'b1;
                started_q <= 1'b0;
                hcnt_q    <= '0;
                hsr_q     <= '0;
            end else if (cs_fall_i && active_q) begin
                done_o       <= 1'b1;
                cmd_o        <= hdr_full_o ? cmd_cur_o : CMD_NONE;
                addr_o       <= hsr_q[ADDR_W-1:0];
                short_pkt_o  <= !hdr_full_o;
                short_word_o <= hdr_full_o && cut_word;
                active_q     <= 1'b0;
                started_q    <= 1'b0;
                hcnt_q       <= '0;
            end else if (active_q && sk_rise_i) begin
                if (!started_q) begin
                    if (si_i) started_q <= 1'b1;
                end else if (!hdr_full_o) begin
                    hsr_q  <= {hsr_q[HDR_W-2:0], si_i};
                    hcnt_q <= hcnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mwmon_word.sv
// Module: data-phase word assembler; streams memory-line words for reads,
// takes one master-line word for writes, ignores everything else.
// Assumes: hdr_full_i rises only after the last address bit was consumed.
module mwmon_word
    import mwmon_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              sk_rise_i,
    input  logic              si_i,
    input  logic              so_i,
    input  logic              hdr_full_i,
    input  mw_cmd_e           cmd_cur_i,
    output logic              word_valid_o,
    output logic              word_dir_o,
    output logic [WORD_W-1:0] word_o,
    output logic              partial_o,
    output logic              taken_o
);

    localparam int WC_W = $clog2(WORD_W);

    logic [WORD_W-1:0] wsr_q;
    logic [WC_W-1:0]   wcnt_q;
    logic              taken_q;
    mw_dphase_e        phase;
    logic              take_bit;
    logic              bit_in;

    assign phase    = phase_of(cmd_cur_i);
    assign bit_in   = (phase == DP_STREAM) ? so_i : si_i;
    assign take_bit = sk_rise_i && hdr_full_i &&
                      ((phase == DP_STREAM) || (phase == DP_ONCE && !taken_q));
    assign partial_o = (wcnt_q != '0);
    assign taken_o   = taken_q;

    // Shift data bits and emit each completed word as a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsr_q        <= '0;
            wcnt_q       <= '0;
            taken_q      <= 1'b0;
            word_valid_o <= 1'b0;
            word_dir_o   <= 1'b0;
            word_o       <= '0;
        end else begin
            word_valid_o <= 1'b0;
            if (clear_i) begin
                wsr_q   <= '0;
                wcnt_q  <= '0;
                taken_q <= 1'b0;
            end else if (take_bit) begin
                if (wcnt_q == WC_W'(WORD_W - 1)) begin
                    word_o       <= {wsr_q[WORD_W-2:0], bit_in};
                    word_valid_o <= 1'b1;
                    word_dir_o   <= (phase == DP_ONCE);
                    wcnt_q       <= '0;
                    if (phase == DP_ONCE) taken_q <= 1'b1;
                end else begin
                    wsr_q  <= {wsr_q[WORD_W-2:0], bit_in};
                    wcnt_q <= wcnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mwmon_top.sv
// Module: passive serial-EEPROM bus monitor (top).
// Assumes: bus signals are far slower than clk (each level held for at least
// three clk cycles); ADDR_W >= 2 and WORD_W >= 2.
module mwmon_top
    import mwmon_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sk_i,
    input  logic              si_i,
    input  logic              so_i,
    output logic              done_o,
    output logic [2:0]        cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              short_pkt_o,
    output logic              short_word_o,
    output logic              word_valid_o,
    output logic              word_dir_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int NSIG = 4;
    localparam int I_CS = 0;
    localparam int I_SK = 1;
    localparam int I_SI = 2;
    localparam int I_SO = 3;

    logic [NSIG-1:0] lvl, rise, fall;
    logic            hdr_full, partial, taken;
    mw_cmd_e         cmd_cur, cmd_rep;

    mwmon_sync #(.N(NSIG), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({so_i, si_i, sk_i, cs_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    mwmon_hdr #(.ADDR_W(ADDR_W)) u_hdr (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_rise_i      (rise[I_CS]),
        .cs_fall_i      (fall[I_CS]),
        .sk_rise_i      (rise[I_SK]),
        .si_i           (lvl[I_SI]),
        .word_partial_i (partial),
        .word_taken_i   (taken),
        .hdr_full_o     (hdr_full),
        .cmd_cur_o      (cmd_cur),
        .done_o         (done_o),
        .cmd_o          (cmd_rep),
        .addr_o         (addr_o),
        .short_pkt_o    (short_pkt_o),
        .short_word_o   (short_word_o)
    );

    mwmon_word #(.WORD_W(WORD_W)) u_word (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (rise[I_CS] | fall[I_CS]),
        .sk_rise_i    (rise[I_SK]),
        .si_i         (lvl[I_SI]),
        .so_i         (lvl[I_SO]),
        .hdr_full_i   (hdr_full),
        .cmd_cur_i    (cmd_cur),
        .word_valid_o (word_valid_o),
        .word_dir_o   (word_dir_o),
        .word_o       (word_o),
        .partial_o    (partial),
        .taken_o      (taken)
    );

    assign cmd_o = cmd_rep;

endmodule

// File: rtl/mwmon_chk.sv
// Module: protocol checker for mwmon_top, attached with bind.
// Assumes: the bus is slow relative to clk, as the top module requires.
module mwmon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done_o,
    input logic [2:0] cmd_o,
    input logic       short_pkt_o,
    input logic       short_word_o,
    input logic       word_valid_o,
    input logic       word_dir_o
);

    logic [3:0] si_words_q;

    // Count master-line words seen since the last end-of-frame report.
    always_ff @(posedge clk) begin
        if (!rst_n)                     si_words_q <= '0;
        else if (done_o)                si_words_q <= '0;
        else if (word_valid_o && word_dir_o && si_words_q != 4'hF)
            si_words_q <= si_words_q + 1'b1;
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && word_valid_o));

    // R6
    short_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && short_pkt_o) |-> (cmd_o == 3'd7));

    // R10
    flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!short_pkt_o && !short_word_o));

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(short_pkt_o && short_word_o));

    // R4
    word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    // R5
    one_si_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && word_dir_o) |-> (si_words_q == 4'd0));

    // R5
    si_word_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && si_words_q != 4'd0) |-> (cmd_o == 3'd1 || cmd_o == 3'd6));

endmodule

bind mwmon_top mwmon_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_o       (done_o),
    .cmd_o        (cmd_o),
    .short_pkt_o  (short_pkt_o),
    .short_word_o (short_word_o),
    .word_valid_o (word_valid_o),
    .word_dir_o   (word_dir_o)
);

// File: tb/sim_mwmon_top.sv
module sim_mwmon_top;

    localparam int AW = 8;
    localparam int WW = 16;
    localparam int HALF = 4;
    localparam int NVEC = 14;

    typedef struct packed {
        logic [1:0]  lead0;
        logic [9:0]  hdr;
        logic [3:0]  hdr_n;
        logic [47:0] dat;
        logic [5:0]  dat_n;
        logic        dat_so;
        logic [2:0]  e_cmd;
        logic        e_sp;
        logic        e_sw;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd0, {2'b10, 8'h5A}, 4'd10, 48'hBEEF_1234_0000, 6'd32, 1'b1, 3'd0, 1'b0, 1'b0},
        '{2'd0, {2'b10, 8'h03}, 4'd10, 48'hC0DE_AB00_0000, 6'd24, 1'b1, 3'd0, 1'b0, 1'b1},
        '{2'd1, {2'b01, 8'hC3}, 4'd10, 48'hA55A_0000_0000, 6'd16, 1'b0, 3'd1, 1'b0, 1'b0},
        '{2'd0, {2'b01, 8'h10}, 4'd10, 48'h8001_FFFF_0000, 6'd32, 1'b0, 3'd1, 1'b0, 1'b0},
        '{2'd0, {2'b01, 8'h22}, 4'd10, 48'h7700_0000_0000, 6'd8,  1'b0, 3'd1, 1'b0, 1'b1},
        '{2'd0, {2'b11, 8'h7F}, 4'd10, 48'h0,              6'd0,  1'b0, 3'd2, 1'b0, 1'b0},
        '{2'd0, {2'b00, 8'hC0}, 4'd10, 48'h0,              6'd0,  1'b0, 3'd3, 1'b0, 1'b0},
        '{2'd0, {2'b00, 8'h00}, 4'd10, 48'h0,              6'd0,  1'b0, 3'd4, 1'b0, 1'b0},
        '{2'd0, {2'b00, 8'h80}, 4'd10, 48'h0,              6'd0,  1'b0, 3'd5, 1'b0, 1'b0},
        '{2'd0, {2'b00, 8'h40}, 4'd10, 48'h0F0F_0000_0000, 6'd16, 1'b0, 3'd6, 1'b0, 1'b0},
        '{2'd0, {2'b10, 8'hFF}, 4'd6,  48'h0,              6'd0,  1'b0, 3'd7, 1'b1, 1'b0},
        '{2'd3, {2'b10, 8'h81}, 4'd10, 48'h4321_0000_0000, 6'd16, 1'b1, 3'd0, 1'b0, 1'b0},
        '{2'd0, {2'b10, 8'h00}, 4'd10, 48'h0,              6'd0,  1'b1, 3'd0, 1'b0, 1'b0},
        '{2'd0, {2'b11, 8'h01}, 4'd10, 48'hFFFF_0000_0000, 6'd16, 1'b0, 3'd2, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_i = 1'b0, sk_i = 1'b0, si_i = 1'b0, so_i = 1'b0;
    logic          done_o, short_pkt_o, short_word_o, word_valid_o, word_dir_o;
    logic [2:0]    cmd_o;
    logic [AW-1:0] addr_o;
    logic [WW-1:0] word_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int            nw = 0;
    int            ndone = 0;
    logic [WW-1:0] got_w [8];
    logic          got_d [8];
    logic [2:0]    g_cmd;
    logic [AW-1:0] g_addr;
    logic          g_sp, g_sw;

    always #5 clk = ~clk;

    mwmon_top #(.ADDR_W(AW), .WORD_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .si_i(si_i), .so_i(so_i),
        .done_o(done_o), .cmd_o(cmd_o), .addr_o(addr_o), .short_pkt_o(short_pkt_o),
        .short_word_o(short_word_o), .word_valid_o(word_valid_o),
        .word_dir_o(word_dir_o), .word_o(word_o)
    );

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run is one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 150000);
            summary();
        end
    end

    // Record outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid_o && nw < 8) begin
                got_w[nw] = word_o;
                got_d[nw] = word_dir_o;
                nw++;
            end
            if (done_o) begin
                ndone++;
                g_cmd = cmd_o; g_addr = addr_o; g_sp = short_pkt_o; g_sw = short_word_o;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_bit(input logic vsi, input logic vso);
        @(negedge clk);
        si_i = vsi; so_i = vso;
        repeat (HALF) @(negedge clk);
        sk_i = 1'b1;
        repeat (HALF) @(negedge clk);
        sk_i = 1'b0;
    endtask

    task automatic open_frame();
        nw = 0; ndone = 0;
        @(negedge clk);
        cs_i = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic close_frame();
        repeat (HALF) @(negedge clk);
        cs_i = 1'b0; si_i = 1'b0; so_i = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic run_vec(input int idx, input vec_t v);
        int exp_nw;
        logic exp_dir;
        open_frame();
        for (int i = 0; i < int'(v.lead0); i++) bus_bit(1'b0, 1'b0);
        bus_bit(1'b1, 1'b0);
        for (int i = 0; i < int'(v.hdr_n); i++) bus_bit(v.hdr[9-i], 1'b0);
        for (int i = 0; i < int'(v.dat_n); i++) begin
            if (v.dat_so) bus_bit(1'b0, v.dat[47-i]);
            else          bus_bit(v.dat[47-i], 1'b0);
        end
        close_frame();
        exp_dir = (v.e_cmd == 3'd1 || v.e_cmd == 3'd6);
        if (v.e_cmd == 3'd0)  exp_nw = int'(v.dat_n) / WW;
        else if (exp_dir)     exp_nw = (int'(v.dat_n) >= WW) ? 1 : 0;
        else                  exp_nw = 0;
        $display("vector %0d", idx);
        chk("R9 done count", ndone, 1);
        chk("R1/R2 cmd", {29'd0, g_cmd}, {29'd0, v.e_cmd});
        chk("R6 short_pkt", {31'd0, g_sp}, {31'd0, v.e_sp});
        chk("R7 short_word", {31'd0, g_sw}, {31'd0, v.e_sw});
        if (!v.e_sp) chk("R3 addr", {24'd0, g_addr}, {24'd0, v.hdr[7:0]});
        chk("R4/R5 word count", nw, exp_nw);
        for (int k = 0; k < exp_nw && k < nw; k++) begin
            chk("R4/R5 word value", {16'd0, got_w[k]}, {16'd0, v.dat[47-16*k -: 16]});
            chk("R4/R5 word dir", {31'd0, got_d[k]}, {31'd0, exp_dir});
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state of every strobe and flag.
        chk("R10 done after reset", {31'd0, done_o}, 32'd0);
        chk("R10 word_valid after reset", {31'd0, word_valid_o}, 32'd0);
        chk("R10 short_pkt after reset", {31'd0, short_pkt_o}, 32'd0);
        chk("R10 short_word after reset", {31'd0, short_word_o}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int v = 0; v < NVEC; v++) run_vec(v, VECS[v]);

        // R8: a frame whose master line never goes high has no start bit.
        open_frame();
        for (int i = 0; i < 20; i++) bus_bit(1'b0, 1'b1);
        close_frame();
        chk("R8 no-start done", ndone, 1);
        chk("R8 no-start short_pkt", {31'd0, g_sp}, 32'd1);
        chk("R8 no-start cmd", {29'd0, g_cmd}, 32'd7);
        chk("R8 no-start no word", nw, 0);

        // R10: idle bus after frames leaves flags low.
        repeat (5) @(negedge clk);
        chk("R10 idle short_pkt", {31'd0, short_pkt_o}, 32'd0);
        chk("R10 idle done", {31'd0, done_o}, 32'd0);

        summary();
    end

endmodule